// File: doc/BRIEF.md
# Arm Submodule Insertion Count and Selector

This block serves one converter arm during the controlled phase of capacitor pre-charge and also during normal nearest-level operation. On every sample strobe it works out how many submodules the arm should have switched in. It then names the individual submodules by walking a list of submodule indices that an external sorter supplies, ordered from lowest to highest capacitor voltage.

In pre-charge mode the count is the grid phase RMS voltage, scaled to its peak, divided by the mean capacitor voltage of the arm and rounded down. Rounding down keeps the arm voltage a little below the grid peak, which limits the current step when the arm leaves the uncontrolled charging phase. In conventional mode the count is the magnitude of the arm voltage reference divided by the rated capacitor voltage, rounded to nearest. Both modes use one shared restoring divider. Its fixed latency is much shorter than a sample period. The insert vector and the count hold their values between updates.

If the arm current charges the capacitors, the lowest-voltage submodules are switched in. If the current discharges them, the highest-voltage submodules are switched in. This pulls the capacitor voltages together.

Top module: `nlm_arm_inserter`

## Requirements
- R1: After synchronous reset, `ins_count` is 0 and `insert_mask` is all zeros.
- R2: With `mode_pre`=1 and S the sum of the N_SM submodule voltages, the count is floor(us_rms·181·N_SM / (128·S)). The factor 181/128 approximates the square root of two, so the quotient is the peak phase voltage over the mean capacitor voltage.
- R3: With `mode_pre`=0, `arm_vref` is read as two's complement. The count is floor((2·|arm_vref| + vc_rated) / (2·vc_rated)), which is the magnitude over the rated voltage rounded half up.
- R4: The count never exceeds N_SM. A larger quotient gives N_SM.
- R5: A zero divisor gives a count of N_SM. That is S=0 in pre-charge mode and vc_rated=0 in conventional mode.
- R6: With `arm_charging`=1, the submodules named at sorted positions 0 to count-1 are inserted. Position p occupies bits [p·IW +: IW] of `sort_idx`, position 0 is the lowest voltage, and bit i of `insert_mask` is submodule i.
- R7: With `arm_charging`=0, the submodules named at the last count positions (N_SM-count to N_SM-1) are inserted.
- R8: Both outputs change only at the LAT-th rising edge after the edge that samples `sample_stb` high, where LAT = DW+1 (29 with default parameters). They hold at every other edge.
- R9: A strobe that arrives while a computation is in progress is ignored.
- R10: When `sort_idx` is a permutation, the number of ones in `insert_mask` equals `ins_count`.
- R11: All operands, the sorted list and the current direction are captured at the strobe edge. Input changes after that edge do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | Start of a new control sample |
| mode_pre | input | 1 | 1 = pre-charge floor mode, 0 = conventional rounding mode |
| arm_vref | input | VW | Signed arm voltage reference (conventional mode) |
| vc_rated | input | VW | Rated capacitor voltage (conventional mode) |
| us_rms | input | VW | Grid phase RMS voltage (pre-charge mode) |
| sm_volt | input | N_SM·VW | Capacitor voltage of each submodule, submodule i at [i·VW +: VW] |
| sort_idx | input | N_SM·IW | Submodule indices in ascending voltage order |
| arm_charging | input | 1 | 1 = arm current charges the capacitors |
| insert_mask | output | N_SM | 1 = submodule inserted, 0 = bypassed |
| ins_count | output | CW | Number of inserted submodules |

## Verification
On every cycle the assertions check three things: the count stays within N_SM, the outputs stay stable whenever the divider has no finished result, and the insert vector carries exactly as many ones as the count. The divider also checks each quotient against its remainder identity. Only the bench scenarios can show the arithmetic of each mode against an independent model. The same applies to the flooring versus half-up rounding, the choice of lowest or highest voltages by current direction, the exact update edge, and that operands captured at a strobe are immune to later input changes and to strobes that arrive while busy.

// File: rtl/nlm_pkg.sv
package nlm_pkg;

  typedef enum logic {
    MODE_CONV      = 1'b0,
    MODE_PRECHARGE = 1'b1
  } nlm_mode_e;

  typedef enum logic {
    DIR_DISCHARGE = 1'b0,
    DIR_CHARGE    = 1'b1
  } nlm_dir_e;

endpackage

// File: rtl/nlm_operand_calc.sv
module nlm_operand_calc
  import nlm_pkg::*;
#(
  parameter int N_SM    = 8,
  parameter int VW      = 16,
  parameter int K_NUM   = 181,
  parameter int K_SHIFT = 7,
  parameter int DW      = 28
) (
  input  nlm_mode_e          mode,
  input  logic [VW-1:0]      arm_vref,
  input  logic [VW-1:0]      vc_rated,
  input  logic [VW-1:0]      us_rms,
  input  logic [N_SM*VW-1:0] sm_volt,
  output logic [DW-1:0]      num,
  output logic [DW-1:0]      den,
  output logic               den_zero
);

  localparam int SW = VW + $clog2(N_SM + 1);

  logic [SW-1:0] part [N_SM+1];
  logic [SW-1:0] volt_sum;
  logic [VW-1:0] vref_mag;

  assign part[0] = '0;
  for (genvar i = 0; i < N_SM; i++) begin : g_acc
    assign part[i+1] = part[i] + SW'(sm_volt[i*VW +: VW]);
  end
  assign volt_sum = part[N_SM];

  assign vref_mag = arm_vref[VW-1] ? (~arm_vref + VW'(1)) : arm_vref;

  always_comb begin
    if (mode == MODE_PRECHARGE) begin
      num      = DW'(us_rms) * DW'(K_NUM) * DW'(N_SM);
      den      = DW'(volt_sum) << K_SHIFT;
      den_zero = (volt_sum == '0);
    end else begin
      num      = (DW'(vref_mag) << 1) + DW'(vc_rated);
      den      = DW'(vc_rated) << 1;
      den_zero = (vc_rated == '0);
    end
  end

endmodule

// File: rtl/nlm_restoring_div.sv
module nlm_restoring_div #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] num_in,
  input  logic [W-1:0] den_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot
);

  localparam int CNTW = $clog2(W + 1);

  logic [W-1:0]    q_r;
  logic [W:0]      rem_r;
  logic [W-1:0]    den_r;
  logic [W-1:0]    num_r;
  logic [CNTW-1:0] cnt_r;
  logic            busy_r;
  logic            done_r;

  logic [W:0]   rem_sh;
  logic [W:0]   rem_nx;
  logic [W-1:0] q_nx;

  always_comb begin
    rem_sh = {rem_r[W-1:0], q_r[W-1]};
    if (rem_sh >= {1'b0, den_r}) begin
      rem_nx = rem_sh - {1'b0, den_r};
      q_nx   = {q_r[W-2:0], 1'b1};
    end else begin
      rem_nx = rem_sh;
      q_nx   = {q_r[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r    <= '0;
      rem_r  <= '0;
      den_r  <= '0;
      num_r  <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start && !busy_r) begin
        q_r    <= num_in;
        num_r  <= num_in;
        den_r  <= den_in;
        rem_r  <= '0;
        cnt_r  <= CNTW'(W);
        busy_r <= 1'b1;
      end else if (busy_r) begin
        q_r   <= q_nx;
        rem_r <= rem_nx;
        cnt_r <= cnt_r - CNTW'(1);
        if (cnt_r == CNTW'(1)) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_r;
  assign done = done_r;
  assign quot = q_r;

  // Quotient and remainder satisfy the division identity (R2, R3)
  assert_div_identity_R2: assert property (@(posedge clk) disable iff (rst)
    (done_r && den_r != '0) |->
      ((2*W)'(q_r) * (2*W)'(den_r) + (2*W)'(rem_r) == (2*W)'(num_r)
       && rem_r < {1'b0, den_r}));

  // A result never appears while an iteration is still running (R8)
  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done_r |-> !busy_r);

endmodule

// File: rtl/nlm_arm_selector.sv
module nlm_arm_selector
  import nlm_pkg::*;
#(
  parameter int N_SM = 8,
  parameter int IW   = 3,
  parameter int CW   = 4
) (
  input  logic [CW-1:0]      count,
  input  logic [N_SM*IW-1:0] order,
  input  nlm_dir_e           dir,
  output logic [N_SM-1:0]    mask
);

  logic [N_SM-1:0] take;
  logic [CW-1:0]   upper_start;

  assign upper_start = CW'(N_SM) - count;

  for (genvar p = 0; p < N_SM; p++) begin : g_pos
    assign take[p] = (dir == DIR_CHARGE) ? (CW'(p) < count)
                                         : (CW'(p) >= upper_start);
  end

  always_comb begin
    mask = '0;
    for (int p = 0; p < N_SM; p++) begin
      if (take[p]) mask[order[p*IW +: IW]] = 1'b1;
    end
  end

endmodule

// File: rtl/nlm_arm_inserter.sv
module nlm_arm_inserter
  import nlm_pkg::*;
#(
  parameter int N_SM    = 8,
  parameter int VW      = 16,
  parameter int K_NUM   = 181,
  parameter int K_SHIFT = 7,
  parameter int IW      = (N_SM > 1) ? $clog2(N_SM) : 1,
  parameter int CW      = $clog2(N_SM + 1),
  parameter int DW      = VW + CW + K_SHIFT + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample_stb,
  input  logic               mode_pre,
  input  logic [VW-1:0]      arm_vref,
  input  logic [VW-1:0]      vc_rated,
  input  logic [VW-1:0]      us_rms,
  input  logic [N_SM*VW-1:0] sm_volt,
  input  logic [N_SM*IW-1:0] sort_idx,
  input  logic               arm_charging,
  output logic [N_SM-1:0]    insert_mask,
  output logic [CW-1:0]      ins_count
);

  logic [DW-1:0] op_num;
  logic [DW-1:0] op_den;
  logic          op_zero;
  logic          div_busy;
  logic          div_done;
  logic [DW-1:0] div_q;
  logic          accept;

  logic [N_SM*IW-1:0] order_r;
  nlm_dir_e           dir_r;
  logic               zero_r;

  logic [CW-1:0]   count_c;
  logic [N_SM-1:0] mask_c;
  logic [CW-1:0]   count_r;
  logic [N_SM-1:0] mask_r;

  nlm_operand_calc #(
    .N_SM(N_SM), .VW(VW), .K_NUM(K_NUM), .K_SHIFT(K_SHIFT), .DW(DW)
  ) u_ops (
    .mode     (nlm_mode_e'(mode_pre)),
    .arm_vref (arm_vref),
    .vc_rated (vc_rated),
    .us_rms   (us_rms),
    .sm_volt  (sm_volt),
    .num      (op_num),
    .den      (op_den),
    .den_zero (op_zero)
  );

  assign accept = sample_stb && !div_busy;

  nlm_restoring_div #(.W(DW)) u_div (
    .clk    (clk),
    .rst    (rst),
    .start  (accept),
    .num_in (op_num),
    .den_in (op_den),
    .busy   (div_busy),
    .done   (div_done),
    .quot   (div_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      order_r <= '0;
      dir_r   <= DIR_DISCHARGE;
      zero_r  <= 1'b0;
    end else if (accept) begin
      order_r <= sort_idx;
      dir_r   <= nlm_dir_e'(arm_charging);
      zero_r  <= op_zero;
    end
  end

  always_comb begin
    if (zero_r || div_q > DW'(N_SM)) count_c = CW'(N_SM);
    else                             count_c = div_q[CW-1:0];
  end

  nlm_arm_selector #(.N_SM(N_SM), .IW(IW), .CW(CW)) u_sel (
    .count (count_c),
    .order (order_r),
    .dir   (dir_r),
    .mask  (mask_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count_r <= '0;
      mask_r  <= '0;
    end else if (div_done) begin
      count_r <= count_c;
      mask_r  <= mask_c;
    end
  end

  assign ins_count   = count_r;
  assign insert_mask = mask_r;

  // Count stays inside the arm size (R4)
  assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
    count_r <= CW'(N_SM));

  // Outputs hold unless the divider just finished (R8)
  assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !div_done |=> ($stable(count_r) && $stable(mask_r)));

  // Inserted set size matches the count (R10)
  assert_mask_popcount_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(mask_r) == int'(count_r));

endmodule

// File: tb/nlm_arm_inserter_tb.sv
module nlm_arm_inserter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_SM    = 8;
  localparam int VW      = 16;
  localparam int IW      = 3;
  localparam int CW      = 4;
  localparam int DW      = VW + CW + 7 + 1;
  localparam int LAT     = DW + 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               sample_stb = 1'b0;
  logic               mode_pre = 1'b0;
  logic [VW-1:0]      arm_vref = '0;
  logic [VW-1:0]      vc_rated = '0;
  logic [VW-1:0]      us_rms = '0;
  logic [N_SM*VW-1:0] sm_volt = '0;
  logic [N_SM*IW-1:0] sort_idx = '0;
  logic               arm_charging = 1'b0;
  logic [N_SM-1:0]    insert_mask;
  logic [CW-1:0]      ins_count;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int volts [N_SM];
  int order [N_SM];
  int exp_cnt = 0;
  int exp_mask = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nlm_arm_inserter dut_i (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .mode_pre(mode_pre),
    .arm_vref(arm_vref), .vc_rated(vc_rated), .us_rms(us_rms),
    .sm_volt(sm_volt), .sort_idx(sort_idx), .arm_charging(arm_charging),
    .insert_mask(insert_mask), .ins_count(ins_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int ref_count(input bit pre, input int vref_s, input int rated,
                                   input int us);
    longint num, den, q, s;
    s = 0;
    for (int i = 0; i < N_SM; i++) s += longint'(volts[i]);
    if (pre) begin
      num = longint'(us) * 181 * N_SM;
      den = s * 128;
    end else begin
      num = 2 * longint'(vref_s < 0 ? -vref_s : vref_s) + longint'(rated);
      den = 2 * longint'(rated);
    end
    if (den == 0) return N_SM;
    q = num / den;
    return (q > N_SM) ? N_SM : int'(q);
  endfunction

  function automatic int ref_mask(input int cnt, input bit chg);
    int m = 0;
    for (int p = 0; p < N_SM; p++) begin
      if (chg ? (p < cnt) : (p >= N_SM - cnt)) m |= (1 << order[p]);
    end
    return m;
  endfunction

  task automatic drive(input bit pre, input int vref_s, input int rated, input int us,
                       input bit chg);
    mode_pre     = pre;
    arm_vref     = VW'(vref_s);
    vc_rated     = VW'(rated);
    us_rms       = VW'(us);
    arm_charging = chg;
    for (int i = 0; i < N_SM; i++) begin
      sm_volt[i*VW +: VW]  = VW'(volts[i]);
      sort_idx[i*IW +: IW] = IW'(order[i]);
    end
  endtask

  task automatic shuffle();
    for (int i = 0; i < N_SM; i++) order[i] = i;
    for (int i = N_SM - 1; i > 0; i--) begin
      int j = int'($urandom % (i + 1));
      int t = order[i];
      order[i] = order[j];
      order[j] = t;
    end
  endtask

  // Full sample: strobe, check hold before the update edge (R8), then result
  task automatic run(input string req, input bit pre, input int vref_s, input int rated,
                     input int us, input bit chg);
    int nc, nm;
    nc = ref_count(pre, vref_s, rated, us);
    nm = ref_mask(nc, chg);
    @(negedge clk);
    drive(pre, vref_s, rated, us, chg);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    chk("R8 hold count", int'(ins_count), exp_cnt);
    chk("R8 hold mask", int'(insert_mask), exp_mask);
    @(posedge clk);
    @(negedge clk);
    exp_cnt  = nc;
    exp_mask = nm;
    chk({req, " count"}, int'(ins_count), nc);
    chk({req, " mask"}, int'(insert_mask), nm);
    chk("R10 popcount", $countones(insert_mask), int'(ins_count));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int a_cnt, a_mask;
    void'($urandom(32'd20250531));
    for (int i = 0; i < N_SM; i++) begin
      volts[i] = 0;
      order[i] = i;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset count", int'(ins_count), 0);
    chk("R1 reset mask", int'(insert_mask), 0);

    // R2 + R6: 1000*1.414/500 -> 2, lowest two by identity order
    for (int i = 0; i < N_SM; i++) volts[i] = 500;
    run("R2 R6 precharge charging", 1'b1, 0, 0, 1000, 1'b1);
    chk("R2 floor value", exp_cnt, 2);
    // R7: highest two
    run("R7 precharge discharging", 1'b1, 0, 0, 1000, 1'b0);
    chk("R7 mask value", exp_mask, 8'hC0);
    // R3: |-250|/100 = 2.5 rounds up to 3
    shuffle();
    run("R3 conventional half-up", 1'b0, -250, 100, 0, 1'b1);
    chk("R3 round value", exp_cnt, 3);
    run("R3 conventional 2.49", 1'b0, 249, 100, 0, 1'b0);
    // R4: clamp
    run("R4 clamp", 1'b0, 5000, 100, 0, 1'b1);
    chk("R4 full arm", exp_mask, 8'hFF);
    // R5: zero divisors
    for (int i = 0; i < N_SM; i++) volts[i] = 0;
    run("R5 zero sum", 1'b1, 0, 0, 300, 1'b0);
    run("R5 zero rated", 1'b0, 0, 0, 300, 1'b1);
    chk("R5 count value", exp_cnt, N_SM);
    // zero grid voltage gives nothing inserted
    for (int i = 0; i < N_SM; i++) volts[i] = 700;
    run("R2 zero grid", 1'b1, 0, 0, 0, 1'b1);

    // R9 + R11: operands A, then B applied and strobed while busy
    shuffle();
    for (int i = 0; i < N_SM; i++) volts[i] = 400;
    a_cnt  = ref_count(1'b1, 0, 0, 1200);
    a_mask = ref_mask(a_cnt, 1'b1);
    @(negedge clk);
    drive(1'b1, 0, 0, 1200, 1'b1);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < N_SM; i++) volts[i] = 50;
    drive(1'b0, 30000, 1000, 4000, 1'b0);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    repeat (LAT - 3) @(posedge clk);
    @(negedge clk);
    chk("R11 captured count", int'(ins_count), a_cnt);
    chk("R11 captured mask", int'(insert_mask), a_mask);
    repeat (LAT + 2) @(posedge clk);
    @(negedge clk);
    chk("R9 busy strobe ignored count", int'(ins_count), a_cnt);
    chk("R9 busy strobe ignored mask", int'(insert_mask), a_mask);
    exp_cnt  = a_cnt;
    exp_mask = a_mask;

    // Random mix of modes, orders and directions
    for (int n = 0; n < 60; n++) begin
      bit pre = bit'($urandom % 2);
      bit chg = bit'($urandom % 2);
      int rated = 100 + int'($urandom % 1900);
      int vref_s = int'($urandom % 24000) - 12000;
      int us = int'($urandom % 4000);
      shuffle();
      for (int i = 0; i < N_SM; i++) volts[i] = int'($urandom % 1200);
      if (pre) run(chg ? "R2 R6 random" : "R2 R7 random", pre, vref_s, rated, us, chg);
      else     run(chg ? "R3 R6 random" : "R3 R7 random", pre, vref_s, rated, us, chg);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule